// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the control and configuration register bank of a host-to-peripheral bridge. It holds 28 registers, each 32 bits wide, that software reaches one whole word at a time over a simple write port and a combinational read port. Both ports take a word index, which is the byte offset from the bank base shifted right by two. Index 0 is byte offset 0x00 and index 27 is byte offset 0x6C. At synchronous reset every register loads a fixed power-on value.

Most registers hold whatever was last written to them. The interrupt enable word cannot be written directly. It changes only through two alias registers: one sets enable bits and one clears them. Each alias also keeps a copy of the last value written to it. The enable word and the interrupt status word ignore writes. One configuration bit acts as a soft-reset trigger: a write that takes it from 0 to 1 produces a one-cycle system reset request.

The block drives four values straight from its registers for neighbouring logic: the enable mask, the edge-select mask, the polarity mask and the address-map word. It also drives the reset request.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: After synchronous active-low reset, the registers hold these values and every other index reads 0:

  | Index | Byte offset | Reset value |
  |---|---|---|
  | 0 | 0x00 | 0x00000C40 |
  | 1 | 0x04 | 0x00001384 |
  | 2 | 0x08 | 0x2BFF8010 |
  | 3 | 0x0C | 0x255E0091 |
  | 4 | 0x10 | 0x00006140 |
  | 7 | 0x1C | 0x000001FF |
  | 8 | 0x20 | 0x000001FF |
  | 26 | 0x68 | 0x00000008 |
  | 27 | 0x6C | 0x10000000 |

  After reset, `irq_en` is 0 and `sys_rst_req` is 0.
- R2: A write to any index in 0..27 other than 12, 13, 14 and 15 stores the written word. The word is readable from the cycle after the write edge. Three outputs follow their registers: `addr_map` follows index 4, `irq_edge` follows index 9 and `irq_pol` follows index 11.
- R3: A write to index 12 (offset 0x30) stores the written word at index 12. It also ORs that word into the enable register, index 14, which drives `irq_en`.
- R4: A write to index 13 (offset 0x34) stores the written word at index 13. It also clears, in the enable register, every bit that is 1 in the written word. If a set and a clear reach the enable register together, the clear wins.
- R5: Writes to index 14 (enable) and to index 15 (status) are ignored. The enable word changes only through R3 and R4, and index 15 always reads 0.
- R6: Take a write to index 1 (offset 0x04) whose data has bit 2 set while the stored bit 2 is 0. `sys_rst_req` is high for exactly the one cycle after that write edge, and the written word is stored as usual.
- R7: A write to index 1 that leaves bit 2 at 1, or that writes bit 2 as 0, gives no reset request.
- R8: Reads of indices 28..63 return 0. Writes to those indices change no register.
- R9: Asserting reset in the middle of operation restores all of the R1 values and drops any pending reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_idx | input | IDX_W (6) | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | IDX_W (6) | Word index of the read |
| rd_data | output | 32 | Combinational read data for `rd_idx` |
| irq_en | output | 32 | Interrupt enable mask (index 14) |
| irq_edge | output | 32 | Edge-select mask (index 9) |
| irq_pol | output | 32 | Polarity mask (index 11) |
| addr_map | output | 32 | Address-map word (index 4) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The enable register is driven with overlapping set and clear masks, so the checks can tell a true OR and AND-NOT from a plain store or a whole-word overwrite. The soft-reset bit is written three ways: first as 0, then as a 0-to-1 change (which follows the reset value of 1 being cleared), and then as 1 again while already 1. These three cases separate detection of a rising edge from detection of a level. Writes aimed at the read-only words and at out-of-range indices are followed by reads of neighbouring words, which would show any aliasing. A long pseudo-random mix of writes and reads is then compared every cycle against a behavioural model of the bank.

// File: rtl/hbr_pkg.sv
// Package: shared constants for the host bridge control register file.
// Assumes word indices as seen on the bus (byte offset >> 2).
package hbr_pkg;
    localparam int NUM_REGS  = 28;
    localparam int DATA_W    = 32;
    localparam int IDX_GEN   = 1;   // general configuration word
    localparam int IDX_MAP   = 4;   // address-map word
    localparam int IDX_EDGE  = 9;   // edge-select mask
    localparam int IDX_POL   = 11;  // polarity mask
    localparam int IDX_ESET  = 12;  // enable-set alias
    localparam int IDX_ECLR  = 13;  // enable-clear alias
    localparam int IDX_EN    = 14;  // enable mask, read-only
    localparam int IDX_STAT  = 15;  // status, read-only
    localparam int SOFT_BIT  = 2;   // soft-reset trigger bit in IDX_GEN

    // Power-on value of each register word
    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7, 8:    return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/hbr_idx_dec.sv
// Module: turns a write index and strobe into a one-hot per-register select.
// Assumes indices at or above NREGS select nothing.
module hbr_idx_dec #(
    parameter int IDX_W = 6,
    parameter int NREGS = 28
) (
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output logic [NREGS-1:0] sel
);
    // One-hot decode of the addressed word
    always_comb begin
        sel = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (we && (idx == IDX_W'(i))) sel[i] = 1'b1;
        end
    end
endmodule

// File: rtl/hbr_word.sv
// Module: one plain read/write register word with a fixed power-on value.
// Assumes synchronous active-low reset.
module hbr_word #(
    parameter int                W     = 32,
    parameter logic [W-1:0]      RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load power-on value or store written word
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_V;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/hbr_en_word.sv
// Module: enable mask modified only by set and clear masks.
// Assumes clear takes precedence when both strobes are active.
module hbr_en_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m, clr_m;

    // Masks active only while their strobe is high
    always_comb begin
        set_m = set_we ? wdata : '0;
        clr_m = clr_we ? wdata : '0;
    end

    // OR in set bits, then knock out clear bits
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/hbr_rise_pulse.sv
// Module: one-cycle request when a write takes a stored bit from 0 to 1.
// Assumes the pulse appears in the cycle after the write edge.
module hbr_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic new_bit,
    input  logic cur_bit,
    output logic pulse
);
    // Register the 0-to-1 write condition for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= we && new_bit && !cur_bit;
    end
endmodule

// File: rtl/hbr_ctrl_regs.sv
// Module: host bridge control register file, 28 words of 32 bits.
// Assumes whole-word access by word index; indices past the bank read 0.
module hbr_ctrl_regs
    import hbr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] irq_en,
    output logic [DATA_W-1:0] irq_edge,
    output logic [DATA_W-1:0] irq_pol,
    output logic [DATA_W-1:0] addr_map,
    output logic              sys_rst_req
);
    localparam int NREGS = NUM_REGS;

    logic [NREGS-1:0]  sel;
    logic [DATA_W-1:0] regs [NREGS];
    logic              gen_soft_bit;

    hbr_idx_dec #(.IDX_W(IDX_W), .NREGS(NREGS)) u_dec (
        .we  (wr_en),
        .idx (wr_idx),
        .sel (sel)
    );

    // Per-word storage, variant picked by index
    for (genvar i = 0; i < NREGS; i++) begin : g_word
        if (i == IDX_EN) begin : g_en
            hbr_en_word #(.W(DATA_W)) u_en (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_we (sel[IDX_ESET]),
                .clr_we (sel[IDX_ECLR]),
                .wdata  (wr_data),
                .q      (regs[i])
            );
        end else if (i == IDX_STAT) begin : g_ro
            assign regs[i] = reset_value(i);
        end else begin : g_rw
            hbr_word #(.W(DATA_W), .RST_V(reset_value(i))) u_w (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (sel[i]),
                .wdata (wr_data),
                .q     (regs[i])
            );
        end
    end

    assign gen_soft_bit = regs[IDX_GEN][SOFT_BIT];

    hbr_rise_pulse u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sel[IDX_GEN]),
        .new_bit (wr_data[SOFT_BIT]),
        .cur_bit (gen_soft_bit),
        .pulse   (sys_rst_req)
    );

    // Read mux; unmatched indices give zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs[i];
        end
    end

    assign irq_en   = regs[IDX_EN];
    assign irq_edge = regs[IDX_EDGE];
    assign irq_pol  = regs[IDX_POL];
    assign addr_map = regs[IDX_MAP];
endmodule

// File: rtl/hbr_ctrl_regs_chk.sv
// Module: temporal checks for the register file, bound to its top.
// Assumes synchronous active-low reset; all checks are off during reset.
module hbr_ctrl_regs_chk
    import hbr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] irq_en,
    input logic [DATA_W-1:0] irq_edge,
    input logic [DATA_W-1:0] addr_map,
    input logic              gen_bit,
    input logic              sys_rst_req
);
    logic w_set, w_clr, w_gen;
    assign w_set = wr_en && (wr_idx == IDX_W'(IDX_ESET));
    assign w_clr = wr_en && (wr_idx == IDX_W'(IDX_ECLR));
    assign w_gen = wr_en && (wr_idx == IDX_W'(IDX_GEN));

    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_set && !w_clr) |=> ((irq_en & $past(wr_data)) == $past(wr_data)));

    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> ((irq_en & $past(wr_data)) == '0));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_set && !w_clr) |=> $stable(irq_en));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> $past(w_gen && wr_data[SOFT_BIT] && !gen_bit));

    p_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (w_gen && (gen_bit || !wr_data[SOFT_BIT])) |=> !sys_rst_req);

    p_map_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_MAP)) |=> (addr_map == $past(wr_data)));

    p_edge_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_EDGE)) |=> (irq_edge == $past(wr_data)));
endmodule

bind hbr_ctrl_regs hbr_ctrl_regs_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .irq_en      (irq_en),
    .irq_edge    (irq_edge),
    .addr_map    (addr_map),
    .gen_bit     (gen_soft_bit),
    .sys_rst_req (sys_rst_req)
);

// File: tb/sim_hbr_ctrl_regs.sv
// Bench: directed checks plus a per-cycle behavioural model comparison.
module sim_hbr_ctrl_regs;
    localparam int IW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [31:0] rd_data, irq_en, irq_edge, irq_pol, addr_map;
    logic        sys_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    hbr_ctrl_regs #(.IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .irq_en(irq_en), .irq_edge(irq_edge), .irq_pol(irq_pol),
        .addr_map(addr_map), .sys_rst_req(sys_rst_req)
    );

    always #5 clk = ~clk;

    // Behavioural model state
    logic [31:0] m [28];
    logic        m_req = 1'b0;

    function automatic logic [31:0] por(input int i);
        case (i)
            0: return 32'h0000_0C40;
            1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;
            3: return 32'h255E_0091;
            4: return 32'h0000_6140;
            7: return 32'h0000_01FF;
            8: return 32'h0000_01FF;
            26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 28; i++) m[i] = por(i);
            m_req = 1'b0;
        end else begin
            m_req = 1'b0;
            if (wr_en) begin
                int k;
                k = int'(wr_idx);
                if (k == 12) begin
                    m[12] = wr_data;
                    m[14] = m[14] | wr_data;
                end else if (k == 13) begin
                    m[13] = wr_data;
                    m[14] = m[14] & ~wr_data;
                end else if (k == 1) begin
                    if (wr_data[2] && !m[1][2]) m_req = 1'b1;
                    m[1] = wr_data;
                end else if (k < 28 && k != 14 && k != 15) begin
                    m[k] = wr_data;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model every cycle
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R3 model irq_en", irq_en, m[14]);
            chk("R2 model irq_edge", irq_edge, m[9]);
            chk("R2 model irq_pol", irq_pol, m[11]);
            chk("R2 model addr_map", addr_map, m[4]);
            chk("R6 model sys_rst_req", {31'b0, sys_rst_req}, {31'b0, m_req});
            chk("R8 model rd_data", rd_data, (int'(rd_idx) < 28) ? m[int'(rd_idx)] : 32'h0);
        end
    end

    task automatic summary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Drive one write; returns at the falling edge after the write edge
    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        rd_idx = IW'(idx);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] lf;
        do_reset();
        // R1 reset state
        for (int i = 0; i < 28; i++) rd_chk("R1 reset value", i, por(i));
        chk("R1 irq_en reset", irq_en, 32'h0);
        chk("R1 sys_rst_req reset", {31'b0, sys_rst_req}, 32'h0);
        chk("R1 addr_map reset", addr_map, 32'h6140);

        // R2 plain storage
        wr(4, 32'hA5A5_0001);
        chk("R2 addr_map", addr_map, 32'hA5A5_0001);
        wr(9, 32'h0000_00F0);
        chk("R2 irq_edge", irq_edge, 32'h0000_00F0);
        wr(11, 32'h0000_000F);
        chk("R2 irq_pol", irq_pol, 32'h0000_000F);
        wr(22, 32'hDEAD_BEEF);
        rd_chk("R2 plain word 22", 22, 32'hDEAD_BEEF);

        // R3 set alias
        wr(12, 32'h0000_00F3);
        chk("R3 irq_en after set", irq_en, 32'h0000_00F3);
        rd_chk("R3 set alias stored", 12, 32'h0000_00F3);
        wr(12, 32'h0000_0100);
        chk("R3 irq_en OR", irq_en, 32'h0000_01F3);

        // R4 clear alias
        wr(13, 32'h0000_0033);
        chk("R4 irq_en after clear", irq_en, 32'h0000_01C0);
        rd_chk("R4 clear alias stored", 13, 32'h0000_0033);
        rd_chk("R4 set alias kept", 12, 32'h0000_0100);

        // R5 read-only words
        wr(14, 32'hFFFF_FFFF);
        chk("R5 enable write ignored", irq_en, 32'h0000_01C0);
        wr(15, 32'h0000_FFFF);
        rd_chk("R5 status write ignored", 15, 32'h0);

        // R6 and R7 soft reset edge
        wr(1, 32'h0000_1380);
        chk("R7 no pulse writing bit2=0", {31'b0, sys_rst_req}, 32'h0);
        wr(1, 32'h0000_1384);
        #1 chk("R6 pulse after 0-to-1", {31'b0, sys_rst_req}, 32'h1);
        rd_chk("R6 value stored", 1, 32'h0000_1384);
        @(negedge clk); #1;
        chk("R6 pulse one cycle", {31'b0, sys_rst_req}, 32'h0);
        wr(1, 32'h0000_1384);
        #1 chk("R7 no pulse bit2 held", {31'b0, sys_rst_req}, 32'h0);

        // R8 out-of-range indices
        wr(30, 32'h1234_5678);
        wr(63, 32'h1234_5678);
        rd_chk("R8 read idx 30", 30, 32'h0);
        rd_chk("R8 read idx 63", 63, 32'h0);
        rd_chk("R8 idx 27 untouched", 27, 32'h1000_0000);
        rd_chk("R8 idx 0 untouched", 0, 32'h0000_0C40);

        // Pseudo-random traffic against the model
        lf = 32'hACE1_1357;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            @(negedge clk);
            wr_en   = lf[0];
            wr_idx  = IW'(lf[9:5] | {lf[10] & lf[11], 5'b0});
            wr_data = {lf[15:0], lf[31:16]};
            rd_idx  = IW'(lf[20:15]);
        end
        @(negedge clk); wr_en = 1'b0;

        // R9 mid-run reset, with a pending request
        wr(1, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(1); wr_data = 32'h4; rst_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R9 request dropped in reset", {31'b0, sys_rst_req}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R9 irq_en restored", irq_en, 32'h0);
        chk("R9 addr_map restored", addr_map, 32'h6140);
        rd_chk("R9 idx 1 restored", 1, 32'h0000_1384);
        rd_chk("R9 idx 3 restored", 3, 32'h255E_0091);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule